// File: doc/BRIEF.md
# Delta-Rule Perceptron Training Unit

A single neuron that can both evaluate and learn. Input vectors arrive one element per beat on a valid/ready stream. Once the final element of a vector is in, the block forms the weighted sum of the elements plus a bias weight. It passes that sum through a ramp activation and returns the output together with a flag that says whether the output missed the target given with the vector. When the vector is tagged for training, the block then corrects every weight, one weight per cycle, with the gradient-descent delta rule. The ramp slope serves as the activation derivative, and the learning rate is a power of two set by a shift amount.

Weights are loaded through a preload port before use. The bias is an extra weight at the highest address whose input is held at 1.0. While training, the block watches how far each weight moves. When a vector tagged as the end of a pass finishes its update, a one-cycle flag reports that no weight moved by more than a programmable amount since the previous pass end.

Top module: `dr_perceptron`

## Requirements
- R1: After reset `in_ready` is 1, and `res_valid` and `epoch_done` are 0.
- R2: A vector is N_IN accepted beats, element 0 first. `in_target` (signed, 6 fraction bits), `in_train` and `in_pass_end` are taken from the last beat. `in_ready` stays 0 from that beat until the block is idle again.
- R3: The net input is u = sum of w[i]*x[i] plus w[N_IN]*1.0. Weights are 16-bit signed with 12 fraction bits, and inputs are 8-bit signed with 6 fraction bits. `res_y` = clamp(u+0.5, 0, 1), truncated to 6 fraction bits, so its range is 0..64.
- R4: `res_valid` is a one-cycle pulse in the cycle N_IN+2 clock edges after the edge that accepted the last beat.
- R5: `res_err` is 1 exactly when `res_y` differs from the vector's target.
- R6: A vector with `in_train`=0 leaves every weight unchanged.
- R7: With `in_train`=1 and -0.5 < u < 0.5, each weight i gets w += (delta*x[i]) >>> `rate_shift`. Here delta = target - res_y, and the bias input is 1.0 (64).
- R8: When u <= -0.5 or u >= 0.5, the derivative is zero and training changes no weight.
- R9: A weight update that leaves the 16-bit range saturates to 32767 or -32768 instead of wrapping.
- R10: After the update of a training vector tagged with `in_pass_end`, `epoch_done` pulses for one cycle if no weight changed by more than `chg_thresh` during the training vectors since the previous pass end. The pulse comes in the first cycle `in_ready` is high again.
- R11: A preload write (`wl_en`) stores `wl_data` at `wl_addr` only while the block is idle, and is ignored while a vector is being processed. `in_ready` is 0 while `wl_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block accepts a beat |
| in_x | input | 8 | Input element, signed, 6 fraction bits |
| in_target | input | 8 | Desired output, taken on the last beat |
| in_train | input | 1 | 1 = train on this vector, 0 = inference only |
| in_pass_end | input | 1 | Vector closes a training pass |
| wl_en | input | 1 | Weight preload write strobe |
| wl_addr | input | 3 | Weight index, N_IN = bias |
| wl_data | input | 16 | Weight value, signed, 12 fraction bits |
| rate_shift | input | 4 | Learning rate = 2^-rate_shift |
| chg_thresh | input | 16 | Largest weight movement still counted as settled |
| res_valid | output | 1 | Result pulse |
| res_y | output | 8 | Activation output, 0..64 |
| res_err | output | 1 | Output differs from target |
| epoch_done | output | 1 | Pass ended with all weights settled |

## Verification
The ramp is exercised with sums well above the linear range, well below it, exactly at the lower knee and inside it. These separate the clamping limits from the linear slice and show where the knee is. Training vectors inside the linear region, with different targets and shifts, are followed by inference vectors. The later outputs expose the moved weights, so a wrong sign, shift or input pairing shows up. A saturated training vector and an inference vector with a wrong target both show that nothing moved. A vector built to push one weight past +32767 tells clamping from wrapping, because the wrapped weight would flip the next output from 1.0 to 0. Passes with a large threshold, a zero threshold and no movement at all separate the three outcomes of the settle flag.

// File: rtl/dr_pkg.sv
package dr_pkg;
  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_MAC  = 2'd1,
    S_ACT  = 2'd2,
    S_UPD  = 2'd3
  } dr_state_e;
endpackage

// File: rtl/dr_wmem.sv
// Weight store: one write port, one registered read port (RAM-inferable).
module dr_wmem #(
  parameter int DEPTH = 5,
  parameter int WW    = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                 clk,
  input  logic                 we,
  input  logic [AW-1:0]        waddr,
  input  logic signed [WW-1:0] wdata,
  input  logic [AW-1:0]        raddr,
  output logic signed [WW-1:0] rdata
);
  logic signed [WW-1:0] mem [0:DEPTH-1];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/dr_mac.sv
// Multiply-accumulate for the net input, one product per enabled cycle.
module dr_mac #(
  parameter int XW   = 8,
  parameter int WW   = 16,
  parameter int ACCW = 28,
  localparam int PW  = XW + WW
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   clr,
  input  logic                   en,
  input  logic signed [XW-1:0]   x,
  input  logic signed [WW-1:0]   w,
  output logic signed [ACCW-1:0] acc
);
  logic signed [PW-1:0] prod;
  assign prod = x * w;

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= acc + {{(ACCW-PW){prod[PW-1]}}, prod};
  end
endmodule

// File: rtl/dr_ramp.sv
// Ramp activation with its derivative folded into the error term.
module dr_ramp #(
  parameter int XW   = 8,
  parameter int XF   = 6,
  parameter int PF   = 18,
  parameter int ACCW = 28,
  localparam int DW  = XW + 1,
  localparam int SH  = PF - XF
) (
  input  logic signed [ACCW-1:0] u,
  input  logic signed [XW-1:0]   target,
  output logic [XW-1:0]          y,
  output logic signed [DW-1:0]   delta
);
  localparam logic signed [ACCW-1:0] HALF = ACCW'(1) <<< (PF - 1);
  localparam logic [ACCW-1:0]        FULL = ACCW'(1) << PF;
  localparam logic [XW-1:0]          YONE = XW'(1) << XF;

  logic signed [ACCW-1:0] s;
  logic                   below, above, lin;

  assign s     = u + HALF;
  assign below = s[ACCW-1] || (s == '0);
  assign above = !s[ACCW-1] && ($unsigned(s) >= FULL);
  assign lin   = !below && !above;

  always_comb begin
    if (below)      y = '0;
    else if (above) y = YONE;
    else            y = s[SH +: XW];
    delta = lin ? ({target[XW-1], target} - {1'b0, y}) : '0;
  end
endmodule

// File: rtl/dr_update.sv
// Delta-rule step for one weight: shifted product, saturating add, movement test.
module dr_update #(
  parameter int XW  = 8,
  parameter int WW  = 16,
  parameter int SHW = 4,
  localparam int DW  = XW + 1,
  localparam int PRW = DW + XW,
  localparam int SW  = ((WW > PRW) ? WW : PRW) + 1
) (
  input  logic signed [WW-1:0] w_old,
  input  logic signed [XW-1:0] x,
  input  logic signed [DW-1:0] delta,
  input  logic [SHW-1:0]       shift,
  input  logic [WW-1:0]        thresh,
  output logic signed [WW-1:0] w_new,
  output logic                 moved
);
  localparam int WMAX_I = (1 << (WW - 1)) - 1;
  localparam logic signed [SW-1:0] WMAX = SW'(WMAX_I);
  localparam logic signed [SW-1:0] WMIN = SW'(-WMAX_I - 1);

  logic signed [PRW-1:0] prod, step;
  logic signed [SW-1:0]  sum;
  logic signed [WW:0]    diff;
  logic [WW:0]           mag;

  assign prod = delta * x;
  assign step = prod >>> shift;
  assign sum  = {{(SW-WW){w_old[WW-1]}}, w_old} + {{(SW-PRW){step[PRW-1]}}, step};

  always_comb begin
    if (sum > WMAX)      w_new = WMAX[WW-1:0];
    else if (sum < WMIN) w_new = WMIN[WW-1:0];
    else                 w_new = sum[WW-1:0];
  end

  assign diff  = {w_new[WW-1], w_new} - {w_old[WW-1], w_old};
  assign mag   = diff[WW] ? $unsigned(-diff) : $unsigned(diff);
  assign moved = mag > {1'b0, thresh};
endmodule

// File: rtl/dr_perceptron.sv
// Top: vector collection, MAC sweep, activation, per-weight update sweep.
module dr_perceptron
  import dr_pkg::*;
#(
  parameter int N_IN = 4,
  parameter int XW   = 8,
  parameter int XF   = 6,
  parameter int WW   = 16,
  parameter int WF   = 12,   // must equal 2*XF so delta*x lands on the weight grid
  parameter int SHW  = 4,
  localparam int DEPTH = N_IN + 1,
  localparam int AW    = $clog2(DEPTH),
  localparam int PF    = WF + XF,
  localparam int ACCW  = XW + WW + $clog2(DEPTH) + 1,
  localparam int DW    = XW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [XW-1:0]  in_x,
  input  logic [XW-1:0]  in_target,
  input  logic           in_train,
  input  logic           in_pass_end,
  input  logic           wl_en,
  input  logic [AW-1:0]  wl_addr,
  input  logic [WW-1:0]  wl_data,
  input  logic [SHW-1:0] rate_shift,
  input  logic [WW-1:0]  chg_thresh,
  output logic           res_valid,
  output logic [XW-1:0]  res_y,
  output logic           res_err,
  output logic           epoch_done
);
  localparam logic signed [XW-1:0] XONE = XW'(1) <<< XF;
  localparam logic [AW-1:0]        LAST = AW'(N_IN);
  localparam logic [AW-1:0]        LBEAT = AW'(N_IN - 1);

  dr_state_e state;
  logic [AW-1:0] idx, cnt;
  logic signed [XW-1:0] xbuf [0:DEPTH-1];
  logic signed [XW-1:0] tgt_q;
  logic                 train_q, pend_q, moved_q;
  logic signed [DW-1:0] delta_q;

  logic                 accept, accept_last;
  logic signed [XW-1:0] x_cur;
  logic                 mem_we;
  logic [AW-1:0]        mem_waddr, mem_raddr;
  logic signed [WW-1:0] mem_wdata, mem_rdata;
  logic signed [ACCW-1:0] acc;
  logic [XW-1:0]        act_y;
  logic signed [DW-1:0] act_delta;
  logic signed [WW-1:0] upd_w;
  logic                 upd_moved;

  assign in_ready    = (state == S_IDLE) && !wl_en;
  assign accept      = in_valid && in_ready;
  assign accept_last = accept && (cnt == LBEAT);
  assign x_cur       = xbuf[idx];

  // Weight store ports.
  always_comb begin
    mem_we    = 1'b0;
    mem_waddr = wl_addr;
    mem_wdata = wl_data;
    if (state == S_UPD) begin
      mem_we    = 1'b1;
      mem_waddr = idx;
      mem_wdata = upd_w;
    end else if (state == S_IDLE && wl_en && wl_addr <= LAST) begin
      mem_we = 1'b1;
    end
    case (state)
      S_MAC, S_UPD: mem_raddr = (idx == LAST) ? '0 : idx + AW'(1);
      default:      mem_raddr = '0;
    endcase
  end

  dr_wmem #(.DEPTH(DEPTH), .WW(WW)) u_wmem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (mem_waddr),
    .wdata (mem_wdata),
    .raddr (mem_raddr),
    .rdata (mem_rdata)
  );

  dr_mac #(.XW(XW), .WW(WW), .ACCW(ACCW)) u_mac (
    .clk (clk),
    .rst (rst),
    .clr (accept_last),
    .en  (state == S_MAC),
    .x   (x_cur),
    .w   (mem_rdata),
    .acc (acc)
  );

  dr_ramp #(.XW(XW), .XF(XF), .PF(PF), .ACCW(ACCW)) u_ramp (
    .u      (acc),
    .target (tgt_q),
    .y      (act_y),
    .delta  (act_delta)
  );

  dr_update #(.XW(XW), .WW(WW), .SHW(SHW)) u_upd (
    .w_old  (mem_rdata),
    .x      (x_cur),
    .delta  (delta_q),
    .shift  (rate_shift),
    .thresh (chg_thresh),
    .w_new  (upd_w),
    .moved  (upd_moved)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      idx        <= '0;
      cnt        <= '0;
      tgt_q      <= '0;
      train_q    <= 1'b0;
      pend_q     <= 1'b0;
      moved_q    <= 1'b0;
      delta_q    <= '0;
      res_valid  <= 1'b0;
      res_y      <= '0;
      res_err    <= 1'b0;
      epoch_done <= 1'b0;
      for (int i = 0; i < DEPTH; i++) xbuf[i] <= (i == N_IN) ? XONE : '0;
    end else begin
      res_valid  <= 1'b0;
      epoch_done <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            xbuf[cnt] <= in_x;
            if (cnt == LBEAT) begin
              cnt     <= '0;
              idx     <= '0;
              tgt_q   <= in_target;
              train_q <= in_train;
              pend_q  <= in_pass_end;
              state   <= S_MAC;
            end else begin
              cnt <= cnt + AW'(1);
            end
          end
        end
        S_MAC: begin
          if (idx == LAST) begin
            idx   <= '0;
            state <= S_ACT;
          end else begin
            idx <= idx + AW'(1);
          end
        end
        S_ACT: begin
          res_valid <= 1'b1;
          res_y     <= act_y;
          res_err   <= (act_y != tgt_q);
          delta_q   <= act_delta;
          idx       <= '0;
          state     <= train_q ? S_UPD : S_IDLE;
        end
        S_UPD: begin
          if (idx == LAST) begin
            idx   <= '0;
            state <= S_IDLE;
            if (pend_q) begin
              epoch_done <= !(moved_q || upd_moved);
              moved_q    <= 1'b0;
            end else begin
              moved_q <= moved_q || upd_moved;
            end
          end else begin
            idx     <= idx + AW'(1);
            moved_q <= moved_q || upd_moved;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dr_perceptron_chk.sv
module dr_perceptron_chk #(
  parameter int XW = 8,
  parameter int XF = 6,
  parameter int WW = 16,
  parameter int DW = 9
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_ready,
  input logic                 res_valid,
  input logic [XW-1:0]        res_y,
  input logic                 epoch_done,
  input logic                 st_idle,
  input logic                 st_upd,
  input logic                 train_q,
  input logic                 mem_we,
  input logic signed [WW-1:0] mem_wdata,
  input logic signed [WW-1:0] mem_rdata,
  input logic signed [DW-1:0] delta_q
);
  localparam logic [XW-1:0] YONE = XW'(1) << XF;

  AST_RES_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);                                  // R4
  AST_Y_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (res_y <= YONE));                             // R3
  AST_BUSY_BEFORE_RESULT: assert property (@(posedge clk) disable iff (rst)
    $rose(res_valid) |-> $past(!in_ready));                     // R2
  AST_NO_WRITE_INFER: assert property (@(posedge clk) disable iff (rst)
    (!st_idle && !train_q) |-> !mem_we);                        // R6
  AST_FLAT_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    (st_upd && delta_q == '0) |-> (mem_wdata == mem_rdata));    // R8
  AST_EPOCH_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    epoch_done |=> !epoch_done);                                // R10
  AST_PRELOAD_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!st_idle && !st_upd) |-> !mem_we);                         // R11
endmodule

bind dr_perceptron dr_perceptron_chk #(.XW(XW), .XF(XF), .WW(WW), .DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .res_valid  (res_valid),
  .res_y      (res_y),
  .epoch_done (epoch_done),
  .st_idle    (state == dr_pkg::S_IDLE),
  .st_upd     (state == dr_pkg::S_UPD),
  .train_q    (train_q),
  .mem_we     (mem_we),
  .mem_wdata  (mem_wdata),
  .mem_rdata  (mem_rdata),
  .delta_q    (delta_q)
);

// File: tb/sim_dr_perceptron.sv
`timescale 1ns/1ps
module sim_dr_perceptron;
  localparam int N = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [7:0] in_x = '0, in_target = '0;
  logic       in_train = 1'b0, in_pass_end = 1'b0;
  logic       wl_en = 1'b0;
  logic [2:0] wl_addr = '0;
  logic [15:0] wl_data = '0;
  logic [3:0] rate_shift = '0;
  logic [15:0] chg_thresh = '0;
  logic       res_valid;
  logic [7:0] res_y;
  logic       res_err;
  logic       epoch_done;

  int checks = 0, failures = 0;
  int mw [N+1];
  int msh = 0, mthr = 0;
  bit mmoved = 0;

  always #5 clk = ~clk;

  dr_perceptron u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_x(in_x), .in_target(in_target), .in_train(in_train),
    .in_pass_end(in_pass_end), .wl_en(wl_en), .wl_addr(wl_addr),
    .wl_data(wl_data), .rate_shift(rate_shift), .chg_thresh(chg_thresh),
    .res_valid(res_valid), .res_y(res_y), .res_err(res_err),
    .epoch_done(epoch_done)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    mmoved = 0;
  endtask

  task automatic preload(input int a, input int v);
    @(negedge clk);
    wl_en = 1'b1; wl_addr = 3'(a); wl_data = 16'(v);
    #1 check(in_ready == 1'b0, "R11 ready low during preload", int'(in_ready), 0);
    @(negedge clk);
    wl_en = 1'b0;
    mw[a] = v;
  endtask

  task automatic load_all(input int w0, input int w1, input int w2, input int w3, input int wb);
    preload(0, w0); preload(1, w1); preload(2, w2); preload(3, w3); preload(4, wb);
  endtask

  task automatic set_rate(input int sh, input int thr);
    @(negedge clk);
    rate_shift = 4'(sh); chg_thresh = 16'(thr);
    msh = sh; mthr = thr;
  endtask

  // Reference from the requirements: returns expected y, err, epoch; updates model.
  task automatic model(input int xv[N], input int d, input bit tr, input bit pe,
                       output int ey, output bit eerr, output bit eep);
    int u, s, dl, nw, dw, mag;
    bit lin;
    u = mw[N] * 64;
    for (int i = 0; i < N; i++) u += mw[i] * xv[i];
    s = u + 131072;
    lin = (s > 0) && (s < 262144);
    if (s <= 0) ey = 0;
    else if (s >= 262144) ey = 64;
    else ey = s >>> 12;
    eerr = (ey != d);
    dl = lin ? d - ey : 0;
    eep = 1'b0;
    if (tr) begin
      for (int i = 0; i <= N; i++) begin
        dw = (dl * ((i == N) ? 64 : xv[i])) >>> msh;
        nw = mw[i] + dw;
        if (nw > 32767) nw = 32767;
        if (nw < -32768) nw = -32768;
        mag = (nw > mw[i]) ? nw - mw[i] : mw[i] - nw;
        if (mag > mthr) mmoved = 1;
        mw[i] = nw;
      end
      if (pe) begin
        eep = !mmoved;
        mmoved = 0;
      end
    end
  endtask

  task automatic run_vec(input int xv[N], input int d, input bit tr, input bit pe,
                         input bit poke, input string tag);
    int ey, cyc;
    bit eerr, eep, ep;
    model(xv, d, tr, pe, ey, eerr, eep);
    for (int i = 0; i < N; i++) begin
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1; in_x = 8'(xv[i]);
      in_target = 8'(d); in_train = tr; in_pass_end = pe;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, {"R2 busy after last beat ", tag}, int'(in_ready), 0);
    if (poke) begin wl_en = 1'b1; wl_addr = 3'd0; wl_data = 16'h7000; end
    cyc = 0;
    while (cyc < 40) begin
      @(posedge clk); cyc++;
      @(negedge clk);
      wl_en = 1'b0;
      if (res_valid) break;
    end
    check(cyc == N + 2, {"R4 latency ", tag}, cyc, N + 2);
    check(int'(res_y) == ey, {"R3 output ", tag}, int'(res_y), ey);
    check(res_err == eerr, {"R5 error flag ", tag}, int'(res_err), int'(eerr));
    ep = 1'b0;
    while (!in_ready) begin @(negedge clk); ep |= epoch_done; end
    check(ep == eep, {"R10 epoch flag ", tag}, int'(ep), int'(eep));
  endtask

  task automatic t_reset();
    #1;
    check(in_ready == 1'b1, "R1 ready after reset", int'(in_ready), 1);
    check(res_valid == 1'b0, "R1 res_valid after reset", int'(res_valid), 0);
    check(epoch_done == 1'b0, "R1 epoch_done after reset", int'(epoch_done), 0);
  endtask

  task automatic t_infer();
    load_all(4096, -2048, 1024, 0, 0);
    set_rate(0, 0);
    run_vec('{0, 0, 0, 0}, 32, 0, 0, 0, "R3 zero sum");
    run_vec('{64, 0, 0, 0}, 64, 0, 0, 0, "R3 upper clamp");
    run_vec('{0, 64, 0, 0}, 5, 0, 0, 0, "R3 lower knee");
    run_vec('{16, 8, 32, 0}, 52, 0, 0, 0, "R3 linear");
    run_vec('{-40, 20, 0, 100}, 9, 0, 0, 0, "R5 mismatch");
  endtask

  task automatic t_infer_static();
    // R6: wrong target in inference; a repeat must give the same output.
    run_vec('{16, 8, 32, 0}, -100, 0, 0, 0, "R6 first");
    run_vec('{16, 8, 32, 0}, -100, 0, 0, 0, "R6 repeat");
  endtask

  task automatic t_train();
    load_all(1000, -500, 300, 2000, -100);
    set_rate(2, 32767);
    run_vec('{20, -10, 30, 5}, 60, 1, 0, 0, "R7 step a");
    run_vec('{-15, 25, 10, -30}, 2, 1, 0, 0, "R7 step b");
    set_rate(4, 32767);
    run_vec('{40, 40, -20, 10}, 50, 1, 0, 0, "R7 step c");
    run_vec('{20, -10, 30, 5}, 0, 0, 0, 0, "R7 probe a");
    run_vec('{0, 0, 0, 0}, 0, 0, 0, 0, "R7 probe bias");
  endtask

  task automatic t_saturated();
    load_all(8192, 0, 0, 0, 0);
    set_rate(0, 32767);
    run_vec('{64, 0, 0, 0}, -50, 1, 0, 0, "R8 saturated train");
    run_vec('{16, 0, 0, 0}, 0, 0, 0, 0, "R8 probe");
  endtask

  task automatic t_wsat();
    load_all(32700, 32700, 0, 0, 0);
    set_rate(0, 32767);
    run_vec('{127, -127, 0, 0}, 127, 1, 0, 0, "R9 overflow step");
    run_vec('{64, 0, 0, 0}, 64, 0, 0, 0, "R9 clamped probe");
    run_vec('{0, -8, 0, 0}, 0, 0, 0, 0, "R9 other weight probe");
  endtask

  task automatic t_epoch();
    do_reset();
    load_all(500, 500, 500, 500, 0);
    set_rate(3, 32767);
    run_vec('{10, 20, 30, 40}, 50, 1, 0, 0, "R10 big thr 1");
    run_vec('{-10, 5, 0, 20}, 10, 1, 1, 0, "R10 big thr end");
    set_rate(3, 0);
    run_vec('{10, 20, 30, 40}, 60, 1, 0, 0, "R10 zero thr 1");
    run_vec('{-10, 5, 0, 20}, 10, 1, 1, 0, "R10 zero thr end");
    load_all(8192, 0, 0, 0, 0);
    run_vec('{64, 0, 0, 0}, 0, 1, 0, 0, "R10 still 1");
    run_vec('{127, 0, 0, 0}, 0, 1, 1, 0, "R10 still end");
  endtask

  task automatic t_preload_busy();
    load_all(1024, 0, 0, 0, 0);
    run_vec('{16, 0, 0, 0}, 36, 0, 0, 1, "R11 poke during vector");
    run_vec('{16, 0, 0, 0}, 36, 0, 0, 0, "R11 probe after poke");
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_infer();
    t_infer_static();
    t_train();
    t_saturated();
    t_wsat();
    t_epoch();
    t_preload_busy();
    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule